// File: doc/BRIEF.md
# Multiplexed host memory-access port

This block is a slave port through which an external host reads and writes a 256-word internal memory. Address and data share one 16-bit bus. The host frames each phase with an active-low select, an active-high address-latch strobe, and active-low read and write strobes. The block answers with an acknowledge. The acknowledge is the port's only back-pressure. While it is high the port is busy, and the host must not start a new address phase or access. When it is low the port is ready.

The host first runs an address phase, then one or more reads or writes. After each completed access the internal address steps up by one, so a burst needs only one address phase. All host inputs, including the shared bus, pass through a two-flop synchronizer. Every phase boundary is detected on the synchronized copies. The port returns read data on `bus_out` and marks the cycles in which it drives the bus with `bus_oe`, so the pad can be turned around.

Top module: `hp_host_port`

## Requirements
- R1: After reset, `ack` is 0 and `bus_oe` is 0.
- R2: An address phase lasts while select is low and the latch strobe is high. The address taken is the last bus value seen before the phase ends, which happens when select rises or the latch strobe falls.
- R3: An access starts on the first cycle in which select and a strobe (read or write) are both low. `ack` then stays high for exactly 2 cycles, and each access writes or reads memory exactly once.
- R4: If the write strobe rises before `ack` falls, the stored word is the bus value at the end of the strobe. Later bus values are ignored.
- R5: If the write strobe is still low when `ack` falls, the stored word is the bus value at that moment. Values driven earlier in the pulse, or after `ack` falls, are not stored.
- R6: `bus_oe` is high only while the synchronized select and read strobe are both low, and low at all other times, including during writes. Read data on `bus_out` is valid from the cycle in which `ack` falls and holds until the next read completes.
- R7: After each completed read or write, the internal address increments by one. A burst of accesses therefore uses consecutive words.
- R8: The memory holds 256 words of 16 bits, indexed by address bits [7:0]. The address wraps from 16'hFFFF to 16'h0000.
- R9: Strobes seen while select is high start no access: `ack` stays low and memory is unchanged.
- R10: The port sees input changes two clock cycles late. If the write strobe goes low just before clock edge n, `ack` first reads high after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel_n | input | 1 | Host select, active low |
| host_latch | input | 1 | Address-latch strobe, active high |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 16 | Shared address/data bus, input side |
| bus_out | output | 16 | Read data toward the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| ack | output | 1 | Busy (1) / ready (0) acknowledge |

## Verification
The hardest case to reach from the ports is choosing the write-data sample point: a strobe that ends before the acknowledge falls must be told apart from one that outlasts it. The bench drives both. A short pulse is followed by a junk bus value. A long pulse changes the bus once early in the acknowledge window and again after the window closes. Each case is then read back to show which bus value was stored. Address capture at the end of the latch phase, and wraparound at 16'hFFFF, are reached by changing the bus partway through an address phase and by running a two-word burst that starts at the top address.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } hp_state_t;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int         W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST;
      q      <= RST;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/hp_mem.sv
module hp_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[idx];
  end
endmodule

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int LAT    = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW    = $clog2(LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_sel_n,
  input  logic              s_latch,
  input  logic              s_rd_n,
  input  logic              s_wr_n,
  input  logic [DATA_W-1:0] s_bus,
  output logic              mem_we,
  output logic              mem_re,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ack,
  output logic              bus_oe
);
  hp_state_t         state;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] addr;
  logic [DATA_W-1:0] hold;
  logic              lat_act, wr_act, rd_act;
  logic              lat_q, wr_q, rd_q;
  logic              done;

  // phase decode on synchronized strobes
  assign lat_act = !s_sel_n && s_latch;
  assign wr_act  = !s_sel_n && !s_wr_n && !lat_act;
  assign rd_act  = !s_sel_n && !s_rd_n && !lat_act;

  assign done      = (state != ST_IDLE) && (cnt == '0);
  assign mem_we    = done && (state == ST_WRITE);
  assign mem_re    = done && (state == ST_READ);
  assign mem_idx   = addr[IDX_W-1:0];
  // strobe still low at completion: take the live bus; else the value at its end
  assign mem_wdata = wr_act ? s_bus : hold;
  assign bus_oe    = !s_sel_n && !s_rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      addr  <= '0;
      hold  <= '0;
      ack   <= 1'b0;
      lat_q <= 1'b0;
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      lat_q <= lat_act;
      wr_q  <= wr_act;
      rd_q  <= rd_act;
      if (lat_act || wr_act) hold <= s_bus;
      unique case (state)
        ST_IDLE: begin
          if (lat_q && !lat_act) begin
            addr <= hold;
          end else if (wr_act && !wr_q) begin
            state <= ST_WRITE;
            ack   <= 1'b1;
            cnt   <= CW'(LAT - 1);
          end else if (rd_act && !rd_q) begin
            state <= ST_READ;
            ack   <= 1'b1;
            cnt   <= CW'(LAT - 1);
          end
        end
        ST_WRITE, ST_READ: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
            ack   <= 1'b0;
            addr  <= addr + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hp_host_port.sv
module hp_host_port #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int LAT    = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel_n,
  input  logic              host_latch,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              ack
);
  logic [3:0]        s_strb;
  logic [DATA_W-1:0] s_bus;
  logic              mem_we, mem_re;
  logic [IDX_W-1:0]  mem_idx;
  logic [DATA_W-1:0] mem_wdata;

  // order {sel_n, latch, rd_n, wr_n}; idle value 1,0,1,1
  hp_sync #(.W(4), .RST(4'b1011)) strb_sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({host_sel_n, host_latch, host_rd_n, host_wr_n}),
    .q(s_strb)
  );

  hp_sync #(.W(DATA_W), .RST('0)) bus_sync_i (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(s_bus)
  );

  hp_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LAT(LAT)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .s_sel_n(s_strb[3]), .s_latch(s_strb[2]),
    .s_rd_n(s_strb[1]), .s_wr_n(s_strb[0]),
    .s_bus(s_bus),
    .mem_we(mem_we), .mem_re(mem_re), .mem_idx(mem_idx),
    .mem_wdata(mem_wdata), .ack(ack), .bus_oe(bus_oe)
  );

  hp_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .re(mem_re),
    .idx(mem_idx), .wdata(mem_wdata), .rdata(bus_out)
  );
endmodule

// File: rtl/hp_host_port_chk.sv
module hp_host_port_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8,
  parameter int LAT    = 2,
  localparam int HW    = $clog2(LAT + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel_n,
  input logic              host_rd_n,
  input logic              ack,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_out,
  input logic              mem_we,
  input logic              mem_re,
  input logic [IDX_W-1:0]  mem_idx
);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_cnt <= '0;
    else if (ack) hi_cnt <= hi_cnt + 1'b1;
    else          hi_cnt <= '0;
  end

  AST_ACK_RUN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (hi_cnt < HW'(LAT))); // R3
  AST_ACK_RUN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> (hi_cnt == HW'(LAT))); // R3
  AST_ACCESS_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> ack); // R3
  AST_ACCESS_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> !ack); // R3
  AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> ($past(!host_sel_n, 2) && $past(!host_rd_n, 2))); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && $past(!ack)) |-> $stable(bus_out)); // R6
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> (mem_idx == IDX_W'($past(mem_idx) + 1'b1))); // R7
endmodule

bind hp_host_port hp_host_port_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LAT(LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_rd_n(host_rd_n),
  .ack(ack), .bus_oe(bus_oe), .bus_out(bus_out),
  .mem_we(mem_we), .mem_re(mem_re), .mem_idx(mem_idx)
);

// File: tb/hp_host_port_tb_top.sv
module hp_host_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel_n = 1'b1;
  logic        host_latch = 1'b0;
  logic        host_rd_n = 1'b1;
  logic        host_wr_n = 1'b1;
  logic [15:0] bus_in = '0;
  logic [15:0] bus_out;
  logic        bus_oe;
  logic        ack;
  int          checks = 0;
  int          errors = 0;
  bit          done_flag = 0;

  always #5 clk = ~clk;

  hp_host_port dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_latch(host_latch),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .ack(ack)
  );

  function automatic logic [15:0] pat(int i);
    return 16'((i * 16'h9E37) ^ 16'h5A5A);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ack_high(string req);
    for (int i = 0; i < 40 && !ack; i++) tick(1);
    chk(ack, req, ack, 1);
  endtask

  task automatic count_high(string req);
    int n = 0;
    while (ack && n < 40) begin
      n++;
      tick(1);
    end
    chk(n == 2, req, n, 2);
  endtask

  task automatic addr_phase(logic [15:0] first, logic [15:0] last);
    host_sel_n = 0; host_latch = 1; bus_in = first;
    tick(2);
    bus_in = last;
    tick(3);
    host_latch = 0;
    tick(3);
  endtask

  task automatic do_write(logic [15:0] d);
    bus_in = d; host_wr_n = 0;
    wait_ack_high("R3 write ack");
    chk(!bus_oe, "R6 oe low in write", bus_oe, 0);
    count_high("R3 write ack width");
    host_wr_n = 1;
    tick(3);
  endtask

  task automatic do_read(logic [15:0] exp, string req);
    host_rd_n = 0;
    wait_ack_high("R3 read ack");
    count_high("R3 read ack width");
    chk(bus_oe, "R6 oe during read", bus_oe, 1);
    chk(bus_out == exp, req, bus_out, exp);
    host_rd_n = 1;
    tick(3);
    chk(!bus_oe, "R6 oe released", bus_oe, 0);
  endtask

  initial begin
    tick(4);
    rst_n = 1;
    tick(2);
    chk(!ack, "R1 ack reset", ack, 0);
    chk(!bus_oe, "R1 oe reset", bus_oe, 0);

    // R10: sync delay and exact ack window
    addr_phase(16'h0, 16'h0);
    bus_in = 16'h1111; host_wr_n = 0;
    tick(1); chk(!ack, "R10 edge1", ack, 0);
    tick(1); chk(!ack, "R10 edge2", ack, 0);
    tick(1); chk(ack,  "R10 edge3", ack, 1);
    tick(1); chk(ack,  "R3 second busy cycle", ack, 1);
    tick(1); chk(!ack, "R3 ack falls", ack, 0);
    host_wr_n = 1;
    tick(3);

    // full sweep: burst write then burst read (R7, R8)
    addr_phase(16'h0, 16'h0);
    for (int i = 0; i < 256; i++) do_write(pat(i));
    addr_phase(16'h0, 16'h0);
    for (int i = 0; i < 256; i++) do_read(pat(i), "R7 burst readback");

    // R2: address taken at end of latch phase
    addr_phase(16'd3, 16'd40);
    do_read(pat(40), "R2 address at latch end");

    // R4: short write pulse, junk after strobe
    addr_phase(16'd10, 16'd10);
    bus_in = 16'hA5A5; host_wr_n = 0;
    tick(2);
    host_wr_n = 1; bus_in = 16'hDEAD;
    tick(6);
    addr_phase(16'd10, 16'd10);
    do_read(16'hA5A5, "R4 short write data");
    do_read(pat(11), "R4 neighbour untouched");

    // R5: long write, value at ack fall wins
    addr_phase(16'd20, 16'd20);
    bus_in = 16'h0001; host_wr_n = 0;
    tick(1);
    bus_in = 16'hBEEF;
    wait_ack_high("R5 ack");
    for (int i = 0; i < 40 && ack; i++) tick(1);
    bus_in = 16'hC0DE;
    tick(2);
    host_wr_n = 1;
    tick(3);
    addr_phase(16'd20, 16'd20);
    do_read(16'hBEEF, "R5 long write data");

    // R8: wrap at top address
    addr_phase(16'hFFFF, 16'hFFFF);
    do_write(16'h7777);
    do_write(16'h8888);
    addr_phase(16'h00FF, 16'h00FF);
    do_read(16'h7777, "R8 top index");
    addr_phase(16'h0100, 16'h0100);
    do_read(16'h8888, "R8 wrapped index");

    // R9: strobes ignored with select high
    addr_phase(16'd30, 16'd30);
    host_sel_n = 1; bus_in = 16'h4242; host_wr_n = 0; host_rd_n = 0;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      chk(!ack, "R9 no ack without select", ack, 0);
    end
    chk(!bus_oe, "R9 no drive without select", bus_oe, 0);
    host_wr_n = 1; host_rd_n = 1;
    tick(3);
    addr_phase(16'd30, 16'd30);
    do_read(pat(30), "R9 memory unchanged");

    host_sel_n = 1;
    tick(3);
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule